// File: doc/BRIEF.md
# Counter-Mode Block Incrementer

This block advances a counter that sits inside a 128-bit data block, the way a counter-mode cipher steps its per-block counter. The block, a size code, a half select, a byte-order select and a one-cycle increment strobe come in. One clock later the updated block comes out. Only the octets of the selected counter field change. A carry never leaves that field, so the rest of the block (nonce, IV and similar data) passes through unchanged.

The counter width, the half of the block that holds it, and the direction in which a carry travels between octets are all chosen at run time, per strobe. Octet n is bits [8n+7:8n] of the block. The left half is octets 0 to 7 and the right half is octets 8 to 15.

Top module: `ctr_block_incrementer`

## Requirements
- R1: While reset is high, and on the first cycle after it, `blk_out` is all zeros and `out_valid` is 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `inc_stb` high. `blk_out` shows the result of that strobe in the same cycle.
- R3: `size_sel` codes 1, 2, 3, 4 and 5 select counters of 1, 2, 4, 8 and 16 octets (8, 16, 32, 64 and 128 bits).
- R4: A strobe with `size_sel` equal to 0 (off), 6 or 7 (unsupported) copies `blk_in` to `blk_out` unchanged.
- R5: With `big_endian` = 0, a carry moves from octet n to octet n+1. The field starts at octet 0 when `align_right` = 0 and at octet 8 when `align_right` = 1, and it takes the lowest-numbered octets of that half.
- R6: With `big_endian` = 1, a carry moves from octet n to octet n-1. The field starts at octet 7 when `align_right` = 0 and at octet 15 when `align_right` = 1, and it takes the highest-numbered octets of that half.
- R7: At size code 5, `align_right` has no effect. The field is all 16 octets and starts at octet 0 (little-endian) or octet 15 (big-endian).
- R8: When the field is all ones, it wraps to all zeros. No carry enters octets outside the field, and every octet outside the field equals the corresponding octet of `blk_in`.
- R9: In a cycle with no strobe, `blk_out` keeps its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_in | input | 128 | Block holding the counter field |
| size_sel | input | 3 | Counter size code (0 off, 1..5 = 8..128 bits) |
| align_right | input | 1 | 0 = left half (octets 0-7), 1 = right half (octets 8-15) |
| big_endian | input | 1 | 0 = carry toward higher octets, 1 = toward lower octets |
| inc_stb | input | 1 | Increment request, one cycle |
| blk_out | output | 128 | Registered updated block |
| out_valid | output | 1 | High in the cycle after a strobe |

## Verification
The bench uses the default parameters: 8-bit octets and 16 of them. That gives a 128-bit block and a 3-bit size code, so all five counter sizes, the two unsupported codes 6 and 7, and the disabled code can be reached. With only 16 octets, the input patterns can hold long runs of 0xFF octets. Carries therefore ripple right up to the edge of the field, and both wrap and containment are exercised in both halves and in both carry directions. Directed cases pin each field position to a value worked out by hand. A long stream of random settings is also compared every clock against a behavioural model.

// File: rtl/ctr_inc_pkg.sv
package ctr_inc_pkg;

  typedef enum logic [2:0] {
    SZ_OFF = 3'd0,
    SZ_8   = 3'd1,
    SZ_16  = 3'd2,
    SZ_32  = 3'd3,
    SZ_64  = 3'd4,
    SZ_128 = 3'd5
  } ctr_size_e;

  // Octets covered by a size code; zero for off or out-of-range codes.
  function automatic int code_octets(input int code, input int max_code);
    if (code < 1 || code > max_code) return 0;
    return 1 << (code - 1);
  endfunction

endpackage

// File: rtl/ctr_field_decode.sv
// Turns the run-time selects into a contiguous octet mask expressed in
// carry order (position 0 is the first octet the carry would reach).
module ctr_field_decode #(
  parameter int N_OCT  = 16,
  parameter int SIZE_W = 3
) (
  input  logic [SIZE_W-1:0] size_sel,
  input  logic              align_right,
  input  logic              big_endian,
  output logic [N_OCT-1:0]  field_mask
);
  import ctr_inc_pkg::*;

  localparam int HALF     = N_OCT / 2;
  localparam int MAX_CODE = $clog2(N_OCT) + 1;

  int len;
  int start;

  always_comb begin
    len = code_octets(int'(size_sel), MAX_CODE);
    if (len >= N_OCT)
      start = 0;
    else if (align_right != big_endian)
      start = HALF;
    else
      start = 0;
    for (int j = 0; j < N_OCT; j++)
      field_mask[j] = (len > 0) && (j >= start) && (j < start + len);
  end

endmodule

// File: rtl/ctr_octet_order.sv
// Optional octet reversal; applying it twice restores the original order.
module ctr_octet_order #(
  parameter int OCT_W = 8,
  parameter int N_OCT = 16
) (
  input  logic [OCT_W*N_OCT-1:0] din,
  input  logic                   reverse,
  output logic [OCT_W*N_OCT-1:0] dout
);

  for (genvar j = 0; j < N_OCT; j++) begin : g_oct
    assign dout[j*OCT_W +: OCT_W] = reverse ? din[(N_OCT-1-j)*OCT_W +: OCT_W]
                                            : din[j*OCT_W +: OCT_W];
  end

endmodule

// File: rtl/ctr_carry_chain.sv
// Ripple increment across masked octets, in carry order.
module ctr_carry_chain #(
  parameter int OCT_W = 8,
  parameter int N_OCT = 16
) (
  input  logic [OCT_W*N_OCT-1:0] din,
  input  logic [N_OCT-1:0]       field_mask,
  output logic [OCT_W*N_OCT-1:0] dout
);

  logic [N_OCT-1:0] cin;
  logic [N_OCT-2:0] cout;

  for (genvar j = 0; j < N_OCT; j++) begin : g_oct
    logic [OCT_W-1:0] oct;
    assign oct = din[j*OCT_W +: OCT_W];

    if (j == 0) begin : g_first
      assign cin[j] = field_mask[j];
    end else begin : g_rest
      // Field entry point injects the +1; inside the field the carry ripples.
      assign cin[j] = field_mask[j] & (~field_mask[j-1] | cout[j-1]);
    end

    if (j < N_OCT - 1) begin : g_cout
      assign cout[j] = cin[j] & (&oct);
    end

    assign dout[j*OCT_W +: OCT_W] = oct + {{(OCT_W-1){1'b0}}, cin[j]};
  end

endmodule

// File: rtl/ctr_block_incrementer.sv
module ctr_block_incrementer #(
  parameter int OCT_W  = 8,
  parameter int N_OCT  = 16,
  parameter int SIZE_W = 3,
  localparam int BLK_W = OCT_W * N_OCT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic [SIZE_W-1:0] size_sel,
  input  logic              align_right,
  input  logic              big_endian,
  input  logic              inc_stb,
  output logic [BLK_W-1:0]  blk_out,
  output logic              out_valid
);

  logic [N_OCT-1:0] mask;
  logic [BLK_W-1:0] chain_in;
  logic [BLK_W-1:0] chain_out;
  logic [BLK_W-1:0] next_blk;

  ctr_field_decode #(.N_OCT(N_OCT), .SIZE_W(SIZE_W)) u_decode (
    .size_sel    (size_sel),
    .align_right (align_right),
    .big_endian  (big_endian),
    .field_mask  (mask)
  );

  ctr_octet_order #(.OCT_W(OCT_W), .N_OCT(N_OCT)) u_order_in (
    .din     (blk_in),
    .reverse (big_endian),
    .dout    (chain_in)
  );

  ctr_carry_chain #(.OCT_W(OCT_W), .N_OCT(N_OCT)) u_chain (
    .din        (chain_in),
    .field_mask (mask),
    .dout       (chain_out)
  );

  ctr_octet_order #(.OCT_W(OCT_W), .N_OCT(N_OCT)) u_order_out (
    .din     (chain_out),
    .reverse (big_endian),
    .dout    (next_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_out   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= inc_stb;
      if (inc_stb) blk_out <= next_blk;
    end
  end

endmodule

// File: rtl/ctr_block_incrementer_chk.sv
module ctr_block_incrementer_chk #(
  parameter int OCT_W  = 8,
  parameter int N_OCT  = 16,
  parameter int SIZE_W = 3,
  localparam int BLK_W = OCT_W * N_OCT,
  localparam int MAX_CODE = $clog2(N_OCT) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [BLK_W-1:0]  blk_in,
  input logic [SIZE_W-1:0] size_sel,
  input logic              align_right,
  input logic              big_endian,
  input logic              inc_stb,
  input logic [BLK_W-1:0]  blk_out,
  input logic              out_valid
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && blk_out == '0));

  // R2
  strobe_valid_chk: assert property (@(posedge clk) disable iff (rst)
    inc_stb |=> out_valid);

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !inc_stb |=> !out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inc_stb |=> $stable(blk_out));

  // R4
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_stb && (int'(size_sel) == 0 || int'(size_sel) > MAX_CODE))
      |=> blk_out == $past(blk_in));

  // R8
  outside_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_stb && int'(size_sel) == 1 && !align_right && !big_endian)
      |=> blk_out[BLK_W-1:OCT_W] == $past(blk_in[BLK_W-1:OCT_W]));

  // R7
  wrap_full_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_stb && int'(size_sel) == MAX_CODE && blk_in == '1) |=> blk_out == '0);

endmodule

bind ctr_block_incrementer ctr_block_incrementer_chk #(
  .OCT_W(OCT_W), .N_OCT(N_OCT), .SIZE_W(SIZE_W)
) u_chk (
  .clk(clk), .rst(rst), .blk_in(blk_in), .size_sel(size_sel),
  .align_right(align_right), .big_endian(big_endian), .inc_stb(inc_stb),
  .blk_out(blk_out), .out_valid(out_valid)
);

// File: tb/tb_ctr_block_incrementer.sv
`timescale 1ns/1ps
module tb_ctr_block_incrementer;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] blk_in = '0;
  logic [2:0]   size_sel = '0;
  logic         align_right = 1'b0;
  logic         big_endian = 1'b0;
  logic         inc_stb = 1'b0;
  logic [127:0] blk_out;
  logic         out_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";

  logic [127:0] m_out;
  logic         m_v;

  always #4 clk = ~clk;

  ctr_block_incrementer dut (
    .clk(clk), .rst(rst), .blk_in(blk_in), .size_sel(size_sel),
    .align_right(align_right), .big_endian(big_endian), .inc_stb(inc_stb),
    .blk_out(blk_out), .out_valid(out_valid)
  );

  function automatic logic [127:0] ref_inc(logic [127:0] b, int sz, bit right, bit be);
    int k, first, pos, carry, v;
    case (sz)
      1: k = 1;
      2: k = 2;
      3: k = 4;
      4: k = 8;
      5: k = 16;
      default: return b;
    endcase
    if (k == 16) first = be ? 15 : 0;
    else first = (right ? 8 : 0) + (be ? 7 : 0);
    carry = 1;
    for (int i = 0; i < k; i++) begin
      pos = be ? first - i : first + i;
      v = int'(b[pos*8 +: 8]) + carry;
      b[pos*8 +: 8] = v[7:0];
      carry = v / 256;
    end
    return b;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural reference, advanced on every clock
  always @(posedge clk) begin
    if (rst) begin
      m_out <= '0;
      m_v   <= 1'b0;
    end else begin
      m_v <= inc_stb;
      if (inc_stb) m_out <= ref_inc(blk_in, int'(size_sel), align_right, big_endian);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(tag, blk_out, m_out);
      chk(tag, {127'b0, out_valid}, {127'b0, m_v});
    end
  end

  task automatic apply(logic [127:0] b, int sz, bit right, bit be);
    @(negedge clk);
    blk_in = b; size_sel = sz[2:0]; align_right = right; big_endian = be;
    inc_stb = 1'b1;
    @(negedge clk);
    inc_stb = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", blk_out, '0);
    chk("R1", {127'b0, out_valid}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {127'b0, out_valid}, '0);

    // R5 little-endian left, 8-bit wrap; R8 octet 1 untouched
    tag = "R5";
    apply(128'h0000_0000_0000_0000_0000_0000_0000_33FF, 1, 0, 0);
    chk("R8", blk_out, 128'h0000_0000_0000_0000_0000_0000_0000_3300);
    chk("R2", {127'b0, out_valid}, 128'd1);
    apply(128'h0000_0000_0000_0000_0000_0000_0000_00FF, 2, 0, 0);
    chk("R5", blk_out, 128'h0000_0000_0000_0000_0000_0000_0000_0100);
    apply(128'h0000_0000_0000_FFFF_0000_0000_0000_0000, 3, 1, 0);
    chk("R5", blk_out, 128'h0000_0000_0001_0000_0000_0000_0000_0000);
    // R3 64-bit left wrap, octet 8 kept
    tag = "R3";
    apply({56'h0, 8'h5A, 64'hFFFF_FFFF_FFFF_FFFF}, 4, 0, 0);
    chk("R3", blk_out, {56'h0, 8'h5A, 64'h0});

    // R6 big-endian
    tag = "R6";
    apply(128'h0000_0000_0000_0000_FF00_0000_0000_0000, 2, 0, 1);
    chk("R6", blk_out, 128'h0000_0000_0000_0000_0001_0000_0000_0000);
    apply(128'h0000_0000_0000_0000_FFFF_3300_0000_0000, 2, 0, 1);
    chk("R8", blk_out, 128'h0000_0000_0000_0000_0000_3300_0000_0000);
    apply(128'hFFAA_0000_0000_0000_0000_0000_0000_0000, 1, 1, 1);
    chk("R6", blk_out, 128'h00AA_0000_0000_0000_0000_0000_0000_0000);
    apply(128'h0100_0000_0000_00FF_0000_0000_0000_0000, 4, 1, 1);
    chk("R6", blk_out, 128'h0200_0000_0000_00FF_0000_0000_0000_0000);

    // R7 full width ignores alignment
    tag = "R7";
    apply(128'h0000_0000_0000_0000_0000_0000_0000_00FF, 5, 1, 0);
    chk("R7", blk_out, 128'h0000_0000_0000_0000_0000_0000_0000_0100);
    apply({128{1'b1}}, 5, 0, 1);
    chk("R7", blk_out, '0);

    // R4 off and unsupported codes
    tag = "R4";
    apply(128'h0123_4567_89AB_CDEF_FFFF_FFFF_FFFF_FFFF, 0, 0, 0);
    chk("R4", blk_out, 128'h0123_4567_89AB_CDEF_FFFF_FFFF_FFFF_FFFF);
    apply(128'hFFFF_FFFF_0000_1111_2222_3333_4444_55FF, 6, 1, 1);
    chk("R4", blk_out, 128'hFFFF_FFFF_0000_1111_2222_3333_4444_55FF);
    apply(128'h0000_0000_0000_0000_0000_0000_0000_00FF, 7, 0, 0);
    chk("R4", blk_out, 128'h0000_0000_0000_0000_0000_0000_0000_00FF);

    // R9 hold without strobe
    tag = "R9";
    @(negedge clk);
    blk_in = 128'h5;
    size_sel = 3'd1;
    repeat (3) @(negedge clk);
    chk("R9", blk_out, 128'h0000_0000_0000_0000_0000_0000_0000_00FF);
    chk("R2", {127'b0, out_valid}, '0);

    // Random stream against the reference model
    tag = "R3";
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      for (int o = 0; o < 16; o++)
        blk_in[o*8 +: 8] = ($urandom % 2) ? 8'hFF : 8'($urandom);
      size_sel    = 3'($urandom);
      align_right = 1'($urandom);
      big_endian  = 1'($urandom);
      inc_stb     = ($urandom % 3) != 0;
    end
    @(negedge clk);
    inc_stb = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule